// File: doc/BRIEF.md
# Telemetry Frame Transmitter

This block turns outgoing telemetry messages into framed byte streams for a UART transmitter that lives outside it. A requester offers one message per cycle. The message is either a raw message, with its own type, length and payload bytes, or one of two fixed records that the block packs itself: a balance status record, or a motor telemetry record for the left or right wheel. Messages wait in a small request queue. The queue never pushes back: a message offered while it is full is thrown away, and a saturating counter records the loss.

A serializer takes the queued messages in arrival order. For each one it sends a start byte, the length, the type, the payload and a CRC-8 check byte. Every byte crosses a valid/ready handshake to the downstream transmitter. The CRC is built up one byte at a time as the length, type and payload bytes are accepted, so the check byte is ready the cycle after the last covered byte leaves.

Top module: `telem_framer`

## Requirements
- R1: Each frame is the byte 0xAA, then the length byte, the type byte, the payload bytes in order, and one CRC byte, for a total of length plus 4 bytes.
- R2: The CRC byte is CRC-8 with polynomial 0x07, initial value 0x00, MSB first and no reflection or final XOR. It covers the length byte, the type byte and the payload bytes.
- R3: When a frame has length 0, its CRC byte follows the type byte directly.
- R4: A byte moves on only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R5: When `req_kind` = 1 (status), the frame has type 0x10 and length 8. Its payload is pitch[15:8], pitch[7:0], motor[15:8], motor[7:0], vbat[15:8], vbat[7:0], state, flags.
- R6: When `req_kind` = 2 (left motor) or 3 (right motor), the frame has type 0x11 or 0x12 and length 10. Its payload is erpm[31:24], erpm[23:16], erpm[15:8], erpm[7:0], mv[15:8], mv[7:0], ma[15:8], ma[7:0], temp[15:8], temp[7:0].
- R7: When `req_kind` = 0 (raw), the frame carries `req_type` and `req_len`. Payload byte i is `req_payload[8*i+7:8*i]`.
- R8: The request queue holds DEPTH messages (default 4), and one more message can be in transmission at the same time. A request offered while the queue is full is dropped and counted. A request offered while the queue has room is never dropped.
- R9: `drop_count` rises by one for each dropped request and stays at its all-ones value once it gets there.
- R10: Frames go out in the order their requests were accepted. The next frame's 0xAA is offered in the cycle after the previous CRC byte is accepted, if a message is waiting.
- R11: After reset, `tx_valid` is low and `drop_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A message is offered this cycle |
| req_kind | input | 2 | 0 raw, 1 status, 2 left motor, 3 right motor |
| req_type | input | 8 | Type byte of a raw message |
| req_len | input | $clog2(MAX_PAYLOAD+1) | Payload length of a raw message |
| req_payload | input | 8*MAX_PAYLOAD | Raw payload, byte i at bits 8i+7..8i |
| st_pitch | input | 16 | Pitch ×10, signed |
| st_motor | input | 16 | Motor command, signed |
| st_vbat | input | 16 | Battery millivolts |
| st_state | input | 8 | Balance state byte |
| st_flags | input | 8 | Flags byte |
| mot_erpm | input | 32 | Electrical RPM, signed |
| mot_mv | input | 16 | Motor supply millivolts |
| mot_ma | input | 16 | Motor current in milliamps, signed |
| mot_temp | input | 16 | Temperature ×10 |
| tx_valid | output | 1 | A frame byte is offered |
| tx_data | output | 8 | Offered frame byte |
| tx_ready | input | 1 | Downstream accepts the byte |
| drop_count | output | DROP_W | Saturating count of dropped requests |

## Verification
The assertions assume that a raw request never has a length above MAX_PAYLOAD. The stimulus keeps every raw length between 0 and 16. They also assume that `tx_ready` may change in any cycle, and the stimulus covers this with a ready line that is always high, one driven by a pseudo-random sequence, and one held low so that the queue fills. Requests come at most one per cycle, back to back. The full-queue cases are set up with the serializer idle and the ready line low, so the number of dropped requests can be worked out in advance.

// File: rtl/telem_pkg.sv
`timescale 1ns/1ps
package telem_pkg;

    localparam logic [7:0] SYNC_BYTE    = 8'hAA;
    localparam logic [7:0] CRC_POLY     = 8'h07;
    localparam logic [7:0] TYPE_STATUS  = 8'h10;
    localparam logic [7:0] TYPE_MOTOR_L = 8'h11;
    localparam logic [7:0] TYPE_MOTOR_R = 8'h12;
    localparam int         STATUS_BYTES = 8;
    localparam int         MOTOR_BYTES  = 10;

    typedef enum logic [1:0] {
        KIND_RAW     = 2'd0,
        KIND_STATUS  = 2'd1,
        KIND_MOTOR_L = 2'd2,
        KIND_MOTOR_R = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        SER_IDLE,
        SER_SYNC,
        SER_LEN,
        SER_TYPE,
        SER_PAY,
        SER_CRC
    } ser_state_e;

    // One byte folded into a running CRC-8, most significant bit first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] data);
        logic [7:0] c;
        c = crc_in ^ data;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/telem_packer.sv
`timescale 1ns/1ps
module telem_packer
    import telem_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16,
    localparam int LW = $clog2(MAX_PAYLOAD + 1),
    localparam int PW = 8 * MAX_PAYLOAD
) (
    input  logic [1:0]    kind,
    input  logic [7:0]    raw_type,
    input  logic [LW-1:0] raw_len,
    input  logic [PW-1:0] raw_payload,
    input  logic [15:0]   st_pitch,
    input  logic [15:0]   st_motor,
    input  logic [15:0]   st_vbat,
    input  logic [7:0]    st_state,
    input  logic [7:0]    st_flags,
    input  logic [31:0]   mot_erpm,
    input  logic [15:0]   mot_mv,
    input  logic [15:0]   mot_ma,
    input  logic [15:0]   mot_temp,
    output logic [7:0]    msg_type,
    output logic [LW-1:0] msg_len,
    output logic [PW-1:0] msg_payload
);

    // Both fixed records are big-endian: most significant byte goes first on the wire.
    logic [8*STATUS_BYTES-1:0] status_be;
    logic [8*MOTOR_BYTES-1:0]  motor_be;

    always_comb begin
        status_be = '0;
        status_be[0*8 +: 8] = st_pitch[15:8];
        status_be[1*8 +: 8] = st_pitch[7:0];
        status_be[2*8 +: 8] = st_motor[15:8];
        status_be[3*8 +: 8] = st_motor[7:0];
        status_be[4*8 +: 8] = st_vbat[15:8];
        status_be[5*8 +: 8] = st_vbat[7:0];
        status_be[6*8 +: 8] = st_state;
        status_be[7*8 +: 8] = st_flags;
    end

    always_comb begin
        motor_be = '0;
        motor_be[0*8 +: 8] = mot_erpm[31:24];
        motor_be[1*8 +: 8] = mot_erpm[23:16];
        motor_be[2*8 +: 8] = mot_erpm[15:8];
        motor_be[3*8 +: 8] = mot_erpm[7:0];
        motor_be[4*8 +: 8] = mot_mv[15:8];
        motor_be[5*8 +: 8] = mot_mv[7:0];
        motor_be[6*8 +: 8] = mot_ma[15:8];
        motor_be[7*8 +: 8] = mot_ma[7:0];
        motor_be[8*8 +: 8] = mot_temp[15:8];
        motor_be[9*8 +: 8] = mot_temp[7:0];
    end

    always_comb begin
        msg_type    = raw_type;
        msg_len     = raw_len;
        msg_payload = raw_payload;
        unique case (req_kind_e'(kind))
            KIND_STATUS: begin
                msg_type    = TYPE_STATUS;
                msg_len     = LW'(STATUS_BYTES);
                msg_payload = PW'(status_be);
            end
            KIND_MOTOR_L, KIND_MOTOR_R: begin
                msg_type    = (req_kind_e'(kind) == KIND_MOTOR_R) ? TYPE_MOTOR_R : TYPE_MOTOR_L;
                msg_len     = LW'(MOTOR_BYTES);
                msg_payload = PW'(motor_be);
            end
            default: ;
        endcase
    end

    // R6 R5: both records fit in the payload buffer
    always_comb begin
        assert (MAX_PAYLOAD >= MOTOR_BYTES)
            else $error("p_payload_fits_r6: MAX_PAYLOAD below motor record size");
    end

endmodule

// File: rtl/telem_req_fifo.sv
`timescale 1ns/1ps
module telem_req_fifo #(
    parameter int DEPTH  = 4,
    parameter int W      = 32,
    parameter int DROP_W = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [W-1:0]      push_data,
    input  logic              pop,
    output logic [W-1:0]      rd_data,
    output logic              nonempty,
    output logic [DROP_W-1:0] drop_count
);

    typedef struct packed {
        logic [AW-1:0]     wr;
        logic [AW-1:0]     rd;
        logic [CW-1:0]     cnt;
        logic [DROP_W-1:0] drops;
    } fifo_regs_t;

    fifo_regs_t d, q;
    logic [W-1:0] mem_q [DEPTH];
    logic full, accept, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full     = (q.cnt == CW'(DEPTH));
    assign nonempty = (q.cnt != '0);
    assign accept   = push_req && !full;
    assign do_pop   = pop && nonempty;
    assign rd_data  = mem_q[q.rd];
    assign drop_count = q.drops;

    always_comb begin
        d = q;
        if (accept) d.wr = ptr_next(q.wr);
        if (do_pop) d.rd = ptr_next(q.rd);
        if (accept && !do_pop)      d.cnt = q.cnt + CW'(1);
        else if (!accept && do_pop) d.cnt = q.cnt - CW'(1);
        if (push_req && full && (q.drops != '1)) d.drops = q.drops + DROP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem_q[q.wr] <= push_data;
    end

    // R8: occupancy never exceeds the queue depth
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    // R8: an accepted request leaves the queue non-empty
    p_accept_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !full) |=> nonempty);
    // R8: the reader never pops an empty queue
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);
    // R9: a dropped request bumps the counter when below saturation
    p_drop_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && (drop_count != '1)) |=> drop_count == $past(drop_count) + DROP_W'(1));
    // R9: a saturated counter stays saturated
    p_drop_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count == '1) |=> drop_count == '1);

endmodule

// File: rtl/telem_serializer.sv
`timescale 1ns/1ps
module telem_serializer
    import telem_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16,
    localparam int LW = $clog2(MAX_PAYLOAD + 1),
    localparam int PW = 8 * MAX_PAYLOAD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_type,
    input  logic [LW-1:0] in_len,
    input  logic [PW-1:0] in_payload,
    output logic          in_pop,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    input  logic          tx_ready
);

    typedef struct packed {
        ser_state_e    st;
        logic [LW-1:0] idx;
        logic [7:0]    crc;
        logic [7:0]    typ;
        logic [LW-1:0] len;
        logic [PW-1:0] pay;
    } ser_regs_t;

    ser_regs_t d, q;
    logic [7:0] len_byte, pay_byte;

    assign len_byte = 8'(q.len);
    assign pay_byte = q.pay[{q.idx, 3'b000} +: 8];

    always_comb begin
        d      = q;
        in_pop = 1'b0;
        unique case (q.st)
            SER_IDLE: begin
                if (in_valid) begin
                    in_pop = 1'b1;
                    d.st   = SER_SYNC;
                    d.typ  = in_type;
                    d.len  = in_len;
                    d.pay  = in_payload;
                    d.idx  = '0;
                    d.crc  = '0;
                end
            end
            SER_SYNC: if (tx_ready) d.st = SER_LEN;
            SER_LEN: begin
                if (tx_ready) begin
                    d.crc = crc8_step(q.crc, len_byte);
                    d.st  = SER_TYPE;
                end
            end
            SER_TYPE: begin
                if (tx_ready) begin
                    d.crc = crc8_step(q.crc, q.typ);
                    d.st  = (q.len == '0) ? SER_CRC : SER_PAY;
                end
            end
            SER_PAY: begin
                if (tx_ready) begin
                    d.crc = crc8_step(q.crc, pay_byte);
                    d.idx = q.idx + LW'(1);
                    if (q.idx + LW'(1) == q.len) d.st = SER_CRC;
                end
            end
            SER_CRC: begin
                if (tx_ready) begin
                    if (in_valid) begin
                        in_pop = 1'b1;
                        d.st   = SER_SYNC;
                        d.typ  = in_type;
                        d.len  = in_len;
                        d.pay  = in_payload;
                        d.idx  = '0;
                        d.crc  = '0;
                    end else begin
                        d.st = SER_IDLE;
                    end
                end
            end
            default: d.st = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SER_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        tx_valid = (q.st != SER_IDLE);
        unique case (q.st)
            SER_SYNC: tx_data = SYNC_BYTE;
            SER_LEN:  tx_data = len_byte;
            SER_TYPE: tx_data = q.typ;
            SER_PAY:  tx_data = pay_byte;
            SER_CRC:  tx_data = q.crc;
            default:  tx_data = 8'h00;
        endcase
    end

    // R4: a stalled byte is held unchanged
    p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R1: a frame opens with the start byte
    p_frame_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_data == SYNC_BYTE);
    // R10: after an accepted check byte, either idle or a new start byte
    p_after_crc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SER_CRC && tx_ready) |=> (!tx_valid || tx_data == SYNC_BYTE));
    // R7: a loaded length never exceeds the payload buffer
    p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> q.len <= LW'(MAX_PAYLOAD));

endmodule

// File: rtl/telem_framer.sv
`timescale 1ns/1ps
module telem_framer
    import telem_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16,
    parameter int DEPTH       = 4,
    parameter int DROP_W      = 8,
    localparam int LW = $clog2(MAX_PAYLOAD + 1),
    localparam int PW = 8 * MAX_PAYLOAD,
    localparam int EW = 8 + LW + PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [7:0]        req_type,
    input  logic [LW-1:0]     req_len,
    input  logic [PW-1:0]     req_payload,
    input  logic [15:0]       st_pitch,
    input  logic [15:0]       st_motor,
    input  logic [15:0]       st_vbat,
    input  logic [7:0]        st_state,
    input  logic [7:0]        st_flags,
    input  logic [31:0]       mot_erpm,
    input  logic [15:0]       mot_mv,
    input  logic [15:0]       mot_ma,
    input  logic [15:0]       mot_temp,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic [DROP_W-1:0] drop_count
);

    logic [7:0]    pk_type;
    logic [LW-1:0] pk_len;
    logic [PW-1:0] pk_pay;
    logic [EW-1:0] q_rd;
    logic          q_nonempty, q_pop;

    telem_packer #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_packer (
        .kind       (req_kind),
        .raw_type   (req_type),
        .raw_len    (req_len),
        .raw_payload(req_payload),
        .st_pitch   (st_pitch),
        .st_motor   (st_motor),
        .st_vbat    (st_vbat),
        .st_state   (st_state),
        .st_flags   (st_flags),
        .mot_erpm   (mot_erpm),
        .mot_mv     (mot_mv),
        .mot_ma     (mot_ma),
        .mot_temp   (mot_temp),
        .msg_type   (pk_type),
        .msg_len    (pk_len),
        .msg_payload(pk_pay)
    );

    telem_req_fifo #(.DEPTH(DEPTH), .W(EW), .DROP_W(DROP_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (req_valid),
        .push_data ({pk_type, pk_len, pk_pay}),
        .pop       (q_pop),
        .rd_data   (q_rd),
        .nonempty  (q_nonempty),
        .drop_count(drop_count)
    );

    telem_serializer #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (q_nonempty),
        .in_type   (q_rd[EW-1 -: 8]),
        .in_len    (q_rd[PW +: LW]),
        .in_payload(q_rd[PW-1:0]),
        .in_pop    (q_pop),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready)
    );

    // R11: nothing is offered in the first cycle out of reset
    p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !tx_valid);

endmodule

// File: tb/test_telem_framer.sv
`timescale 1ns/1ps
module test_telem_framer;

    localparam int MAXP  = 16;
    localparam int DEPTH = 4;
    localparam int DROPW = 8;
    localparam int LW    = $clog2(MAXP + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_kind = '0;
    logic [7:0]       req_type = '0;
    logic [LW-1:0]    req_len = '0;
    logic [8*MAXP-1:0] req_payload = '0;
    logic [15:0]      st_pitch = '0, st_motor = '0, st_vbat = '0;
    logic [7:0]       st_state = '0, st_flags = '0;
    logic [31:0]      mot_erpm = '0;
    logic [15:0]      mot_mv = '0, mot_ma = '0, mot_temp = '0;
    logic             tx_valid;
    logic [7:0]       tx_data;
    logic             tx_ready = 1'b0;
    logic [DROPW-1:0] drop_count;

    telem_framer #(.MAX_PAYLOAD(MAXP), .DEPTH(DEPTH), .DROP_W(DROPW)) i_telem_framer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_type(req_type), .req_len(req_len), .req_payload(req_payload),
        .st_pitch(st_pitch), .st_motor(st_motor), .st_vbat(st_vbat),
        .st_state(st_state), .st_flags(st_flags), .mot_erpm(mot_erpm),
        .mot_mv(mot_mv), .mot_ma(mot_ma), .mot_temp(mot_temp),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .drop_count(drop_count)
    );

    always #2 clk = ~clk;

    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    int         rdy_mode = 2;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] bytes[$]);
        logic [7:0] c = 8'h00;
        foreach (bytes[i]) begin
            c = c ^ bytes[i];
            for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    // Scoreboard producer: the full expected frame for an accepted request.
    task automatic enq(input logic [7:0] t, input logic [7:0] pb[$], input bit drop, input string tag);
        logic [7:0] cov[$];
        if (drop) return;
        cov.push_back(8'(pb.size()));
        cov.push_back(t);
        foreach (pb[i]) cov.push_back(pb[i]);
        exp_q.push_back(8'hAA); tag_q.push_back(tag);
        foreach (cov[i]) begin exp_q.push_back(cov[i]); tag_q.push_back(tag); end
        exp_q.push_back(ref_crc(cov)); tag_q.push_back({tag, " crc R2"});
    endtask

    task automatic send_raw(input logic [7:0] t, input int n, input bit drop, input string tag);
        logic [7:0] pb[$];
        logic [8*MAXP-1:0] flat = '0;
        for (int i = 0; i < n; i++) begin
            flat[8*i +: 8] = t ^ 8'(i * 37 + n);
            pb.push_back(flat[8*i +: 8]);
        end
        @(posedge clk); #1;
        req_valid = 1'b1; req_kind = 2'd0; req_type = t;
        req_len = LW'(n); req_payload = flat;
        enq(t, pb, drop, tag);
    endtask

    task automatic send_status(input logic [15:0] p, input logic [15:0] m, input logic [15:0] v,
                               input logic [7:0] s, input logic [7:0] f, input string tag);
        logic [7:0] pb[$];
        pb = '{p[15:8], p[7:0], m[15:8], m[7:0], v[15:8], v[7:0], s, f};
        @(posedge clk); #1;
        req_valid = 1'b1; req_kind = 2'd1;
        st_pitch = p; st_motor = m; st_vbat = v; st_state = s; st_flags = f;
        req_type = 8'hEE; req_len = LW'(3);
        enq(8'h10, pb, 1'b0, tag);
    endtask

    task automatic send_motor(input bit right, input logic [31:0] e, input logic [15:0] mv,
                              input logic [15:0] ma, input logic [15:0] tp, input string tag);
        logic [7:0] pb[$];
        pb = '{e[31:24], e[23:16], e[15:8], e[7:0], mv[15:8], mv[7:0], ma[15:8], ma[7:0], tp[15:8], tp[7:0]};
        @(posedge clk); #1;
        req_valid = 1'b1; req_kind = right ? 2'd3 : 2'd2;
        mot_erpm = e; mot_mv = mv; mot_ma = ma; mot_temp = tp;
        enq(right ? 8'h12 : 8'h11, pb, 1'b0, tag);
    endtask

    task automatic req_idle();
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Ready driver: 0 always high, 1 pseudo-random, 2 held low.
    initial begin
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0: tx_ready = 1'b1;
                1: tx_ready = lfsr[0] | lfsr[3];
                default: tx_ready = 1'b0;
            endcase
        end
    end

    // Monitor: pops the scoreboard on every accepted byte.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "byte with no frame pending", tx_data, 0);
                end else begin
                    logic [7:0] e;
                    string tg;
                    e = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    check(tx_data === e, tg, "frame byte", tx_data, e);
                end
            end
        end
    end

    initial begin
        #600000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tx_valid == 1'b0, "R11", "tx_valid in reset", tx_valid, 0);
        check(drop_count == '0, "R11", "drop_count in reset", drop_count, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check(tx_valid == 1'b0, "R11", "tx_valid after reset", tx_valid, 0);

        rdy_mode = 0;
        send_raw(8'h21, 3, 1'b0, "R7"); req_idle(); wait_drain();
        send_raw(8'h22, 0, 1'b0, "R3"); req_idle(); wait_drain();
        send_raw(8'h23, MAXP, 1'b0, "R1"); req_idle(); wait_drain();
        send_status(16'hFF85, 16'hF830, 16'd12600, 8'h03, 8'h5A, "R5"); req_idle(); wait_drain();
        send_motor(1'b0, 32'hFFFD_B610, 16'd24100, 16'hF254, 16'd452, "R6"); req_idle(); wait_drain();
        send_motor(1'b1, 32'h0001_81CD, 16'd23950, 16'd1234, 16'd389, "R6"); req_idle(); wait_drain();

        // Back-to-back frames under a random ready line
        rdy_mode = 1;
        send_raw(8'h30, 2, 1'b0, "R10");
        send_status(16'h0042, 16'h0100, 16'd11000, 8'h01, 8'h80, "R10");
        send_raw(8'h31, 0, 1'b0, "R10");
        send_motor(1'b1, 32'h8000_0001, 16'hFFFF, 16'h8000, 16'h0000, "R4");
        send_raw(8'h32, 5, 1'b0, "R4");
        req_idle(); wait_drain();
        check(drop_count == '0, "R8", "no drops with room", drop_count, 0);

        // Fill the queue with ready held low
        rdy_mode = 2;
        repeat (2) @(posedge clk);
        for (int k = 0; k < 8; k++) send_raw(8'h40 + 8'(k), 1 + k, k >= DEPTH + 1, "R8");
        req_idle();
        repeat (2) @(negedge clk);
        check(drop_count == 8'd3, "R8", "drops on full queue", drop_count, 3);
        held = tx_data;
        repeat (3) @(negedge clk);
        check(tx_valid == 1'b1, "R4", "valid held while stalled", tx_valid, 1);
        check(tx_data == held, "R4", "data stable while stalled", tx_data, held);
        check(tx_data == 8'hAA, "R1", "stalled frame start", tx_data, 8'hAA);
        rdy_mode = 0;
        wait_drain();

        // Saturate the drop counter
        rdy_mode = 2;
        repeat (2) @(posedge clk);
        for (int k = 0; k < 265; k++) send_raw(8'h50, 1, k >= DEPTH + 1, "R9");
        req_idle();
        @(negedge clk);
        check(drop_count == 8'hFF, "R9", "counter saturates", drop_count, 8'hFF);
        send_raw(8'h51, 1, 1'b1, "R9"); req_idle();
        @(negedge clk);
        check(drop_count == 8'hFF, "R9", "counter holds at max", drop_count, 8'hFF);
        rdy_mode = 0;
        wait_drain();
        @(negedge clk);
        check(tx_valid == 1'b0, "R10", "idle after last frame", tx_valid, 0);
        check(exp_q.size() == 0, "R10", "all frames seen", exp_q.size(), 0);
        finish_run();
    end

endmodule